// File: doc/BRIEF.md
# Reset Source and Status Controller

This block sequences reset for a small microcontroller core. It merges a power-on indication, an active-low external reset pin and a watchdog expiry into one cold reset. It times the oscillator start-up window and a short configuration-load window after it, then raises a ready output. When the watchdog expires while the core sleeps in HALT, the block does not reset the whole core. It sends a one-cycle warm reset, which firmware uses to clear only the program counter and the stack pointer, and then waits for the start-up window alone.

Two sticky status bits survive every reset except power-on. A time-out bit records a watchdog expiry. A power-down bit records that HALT was entered. Firmware reads this pair after a reset to learn why the reset happened. The core reports HALT entry, wake-up events and watchdog clears to the block through single-cycle strobes. The watchdog counter, the oscillator and the analog reset network are outside the block.

Top module: `rst_status_ctrl`

## Requirements
- R1: While por_n is low, cold_rst is 1, ready is 0, warm_rst is 0 and both flags are 0. After por_n rises, ready goes to 1 exactly SST_CYCLES+OPT_CYCLES+2 clock edges later (1042 with the defaults), and the flags stay 0,0.
- R2: rst_pin_n low forces cold_rst to 1 and ready to 0 at once, without waiting for a clock edge. If the core was not in HALT, the flags keep their values. After the pin is released, ready returns after SST_CYCLES+OPT_CYCLES+2 edges.
- R3: If the pin reset arrives while the core is in HALT, the flags become time-out 0 and power-down 1.
- R4: A wdt_expire strobe while ready is high and the core is not in HALT starts a cold reset. ready returns SST_CYCLES+OPT_CYCLES edges after the strobe edge. Time-out becomes 1 and power-down keeps its value.
- R5: A wdt_expire strobe while the core is in HALT makes warm_rst high for exactly one cycle, with cold_rst staying 0 throughout. Both flags become 1, and ready returns SST_CYCLES edges after the strobe edge, with no configuration-load window.
- R6: A wake_evt strobe while the core is in HALT drops ready for SST_CYCLES edges. It leaves the flags unchanged and produces no cold or warm reset.
- R7: A halt_enter strobe while ready is high sets power-down to 1 from the next cycle and marks the core as being in HALT.
- R8: A clr_wdt strobe while ready is high clears both flags from the next cycle, and ready stays high.
- R9: In the same cycle, wdt_expire takes precedence over clr_wdt and over halt_enter. The result is a normal-run watchdog reset (R4), with time-out 1 and power-down unchanged.
- R10: While ready is low, the strobes wdt_expire, clr_wdt, halt_enter and wake_evt are ignored. The flags and the remaining start-up time do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on good, active low asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| wdt_expire | input | 1 | Watchdog expiry strobe |
| halt_enter | input | 1 | Core entering HALT strobe |
| wake_evt | input | 1 | Port or interrupt wake strobe |
| clr_wdt | input | 1 | Firmware watchdog-clear strobe |
| cold_rst | output | 1 | Full system reset, active high |
| warm_rst | output | 1 | One-cycle pulse clearing program counter and stack pointer |
| ready | output | 1 | Start-up and configuration windows finished |
| flag_to | output | 1 | Time-out status bit |
| flag_pd | output | 1 | Power-down status bit |

## Verification
A watchdog expiry can arrive in the same cycle as a firmware watchdog clear, or in the same cycle as a HALT-entry strobe. Each pair asks for a different flag update, so each is a real collision. The bench provokes both collisions on purpose, mixed with random sequences of pin resets, HALT entries, wakes and expiries. It judges each outcome against a flag model in the bench, which expects time-out set, power-down unchanged and a full cold-reset delay. It also checks that a watchdog strobe inside a wake window leaves both the flags and the wake latency alone.

// File: rtl/rst_status_ctrl.sv
module rst_status_ctrl #(
  parameter int SST_CYCLES = 1024,
  parameter int OPT_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic wdt_expire,
  input  logic halt_enter,
  input  logic wake_evt,
  input  logic clr_wdt,
  output logic cold_rst,
  output logic warm_rst,
  output logic ready,
  output logic flag_to,
  output logic flag_pd
);
  localparam int CW = $clog2(SST_CYCLES > OPT_CYCLES ? SST_CYCLES : OPT_CYCLES);

  typedef enum logic [1:0] {S_COLD, S_OPT, S_WAKE, S_RUN} st_e;

  logic [1:0]    sync_q;
  st_e           state;
  logic [CW-1:0] cnt;
  logic          warm_q, in_halt, pin_prev, to_q, pd_q;

  wire arst_n = por_n & rst_pin_n;
  wire sync_n = sync_q[1];

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};

  wire run      = (state == S_RUN);
  wire wdt_hit  = run & wdt_expire;
  wire warm_go  = wdt_hit & in_halt;
  wire cold_go  = wdt_hit & ~in_halt;
  wire clr_go   = run & ~wdt_expire & clr_wdt;
  wire halt_go  = run & ~wdt_expire & ~clr_wdt & ~in_halt & halt_enter;
  wire wake_go  = run & ~wdt_expire & in_halt & wake_evt;
  wire pin_hit  = pin_prev & ~sync_n;
  wire sst_last = (cnt == CW'(SST_CYCLES - 1));
  wire opt_last = (cnt == CW'(OPT_CYCLES - 1));

  always_ff @(posedge clk or negedge sync_n)
    if (!sync_n) begin
      state  <= S_COLD;
      cnt    <= '0;
      warm_q <= 1'b0;
    end else begin
      warm_q <= warm_go;
      case (state)
        S_COLD:
          if (sst_last) begin state <= S_OPT; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        S_OPT:
          if (opt_last) begin state <= S_RUN; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        S_WAKE:
          if (sst_last) begin state <= S_RUN; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        default: begin
          cnt <= '0;
          if (cold_go) state <= S_COLD;
          else if (warm_go || wake_go) state <= S_WAKE;
        end
      endcase
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pin_prev <= 1'b0;
      in_halt  <= 1'b0;
      to_q     <= 1'b0;
      pd_q     <= 1'b0;
    end else begin
      pin_prev <= sync_n;
      if (pin_hit) begin
        if (in_halt) begin
          to_q <= 1'b0;
          pd_q <= 1'b1;
        end
        in_halt <= 1'b0;
      end else if (wdt_hit) begin
        to_q <= 1'b1;
        if (in_halt) pd_q <= 1'b1;
        in_halt <= 1'b0;
      end else begin
        if (clr_go) begin
          to_q <= 1'b0;
          pd_q <= 1'b0;
        end
        if (halt_go) begin
          pd_q    <= 1'b1;
          in_halt <= 1'b1;
        end
        if (wake_go) in_halt <= 1'b0;
      end
    end

  assign cold_rst = (state == S_COLD) || (state == S_OPT);
  assign warm_rst = warm_q;
  assign ready    = run;
  assign flag_to  = to_q;
  assign flag_pd  = pd_q;

  // R5
  warm_pulse_chk: assert property (@(posedge clk) disable iff (!sync_n)
    warm_rst |=> !warm_rst);

  // R5
  warm_not_cold_chk: assert property (@(posedge clk) disable iff (!sync_n)
    warm_rst |-> (!cold_rst && flag_to && flag_pd));

  // R4
  wdt_cold_chk: assert property (@(posedge clk) disable iff (!sync_n)
    (ready && wdt_expire && !in_halt) |=> (cold_rst && flag_to));

  // R8
  clr_flags_chk: assert property (@(posedge clk) disable iff (!sync_n)
    (ready && clr_wdt && !wdt_expire) |=> (!flag_to && !flag_pd && ready));

  // R7
  halt_pd_chk: assert property (@(posedge clk) disable iff (!sync_n)
    (ready && halt_enter && !wdt_expire && !clr_wdt) |=> flag_pd);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!sync_n)
    (!ready && !cold_rst) |=> (!cold_rst && $stable(flag_to) && $stable(flag_pd)));
endmodule

// File: tb/rst_status_ctrl_test.sv
module rst_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SST = 1024;
  localparam int OPT = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_pin_n = 1'b1;
  logic wdt_expire = 1'b0, halt_enter = 1'b0, wake_evt = 1'b0, clr_wdt = 1'b0;
  logic cold_rst, warm_rst, ready, flag_to, flag_pd;

  int checks = 0;
  int errors = 0;
  logic [1:0] mflags = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_status_ctrl #(.SST_CYCLES(SST), .OPT_CYCLES(OPT)) uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdt_expire(wdt_expire),
    .halt_enter(halt_enter), .wake_evt(wake_evt), .clr_wdt(clr_wdt),
    .cold_rst(cold_rst), .warm_rst(warm_rst), .ready(ready),
    .flag_to(flag_to), .flag_pd(flag_pd));

  // ops: 0 pin run, 1 pin halt, 2 wdt run, 3 wdt halt, 4 wake, 5 clr+wdt, 6 clr, 7 halt+wdt, 8 halt
  function automatic logic [1:0] exp_flags(int op, logic [1:0] f);
    case (op)
      0, 4:    return f;
      1:       return 2'b01;
      2, 5, 7: return {1'b1, f[0]};
      3:       return 2'b11;
      6:       return 2'b00;
      default: return {f[1], 1'b1};
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic strobe(logic w, logic h, logic k, logic c);
    wdt_expire = w; halt_enter = h; wake_evt = k; clr_wdt = c;
    @(posedge clk);
    @(negedge clk);
    wdt_expire = 0; halt_enter = 0; wake_evt = 0; clr_wdt = 0;
  endtask

  task automatic chk_flags(string req);
    chk({req, " flag_to"}, int'(flag_to), int'(mflags[1]));
    chk({req, " flag_pd"}, int'(flag_pd), int'(mflags[0]));
  endtask

  task automatic do_halt();
    strobe(0, 1, 0, 0);
    mflags = exp_flags(8, mflags);
    chk_flags("R7");
    chk("R7 ready", int'(ready), 1);
  endtask

  task automatic pin_reset(string req, int op);
    int n;
    rst_pin_n = 1'b0;
    #1;
    chk("R2 async cold", int'(cold_rst), 1);
    chk("R2 ready low", int'(ready), 0);
    idle(1 + $urandom_range(0, 3));
    rst_pin_n = 1'b1;
    mflags = exp_flags(op, mflags);
    wait_ready(n);
    chk({req, " latency"}, n, SST + OPT + 2);
    chk_flags(req);
  endtask

  task automatic run_op(int op);
    int n;
    case (op)
      0: pin_reset("R2", 0);
      1: begin do_halt(); pin_reset("R3", 1); end
      2, 5, 7: begin
        string r;
        r = (op == 2) ? "R4" : "R9";
        strobe(1, op == 7, 0, op == 5);
        mflags = exp_flags(op, mflags);
        chk({r, " cold"}, int'(cold_rst), 1);
        wait_ready(n);
        chk({r, " latency"}, n, SST + OPT);
        chk_flags(r);
      end
      3: begin
        do_halt();
        strobe(1, 0, 0, 0);
        mflags = exp_flags(3, mflags);
        chk("R5 warm", int'(warm_rst), 1);
        chk("R5 no cold", int'(cold_rst), 0);
        chk_flags("R5");
        @(posedge clk); @(negedge clk);
        chk("R5 warm one cycle", int'(warm_rst), 0);
        wait_ready(n);
        chk("R5 latency", n, SST - 1);
      end
      4: begin
        do_halt();
        strobe(0, 0, 1, 0);
        chk("R6 ready low", int'(ready), 0);
        chk("R6 no reset", int'(cold_rst | warm_rst), 0);
        strobe(1, 1, 1, 1);
        chk("R10 ignored cold", int'(cold_rst), 0);
        wait_ready(n);
        chk("R10 latency", n, SST - 1);
        mflags = exp_flags(4, mflags);
        chk_flags("R10");
      end
      default: begin
        strobe(0, 0, 0, 1);
        mflags = exp_flags(6, mflags);
        chk_flags("R8");
        chk("R8 ready", int'(ready), 1);
      end
    endcase
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed1234));
    idle(3);
    chk("R1 cold", int'(cold_rst), 1);
    chk("R1 ready", int'(ready), 0);
    chk("R1 warm", int'(warm_rst), 0);
    chk_flags("R1");
    por_n = 1'b1;
    wait_ready(n);
    chk("R1 latency", n, SST + OPT + 2);
    chk_flags("R1");
    run_op(2);
    run_op(3);
    run_op(5);
    run_op(1);
    run_op(7);
    run_op(6);
    run_op(4);
    for (int i = 0; i < 30; i++) begin
      idle(1 + $urandom_range(0, 4));
      run_op($urandom_range(0, 7));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule